// File: doc/BRIEF.md
# Cascadable Latched Magnitude Comparator

This block compares two words, P and Q, and raises one of two decision outputs. One output means P is greater than Q and the other means P is less than Q. When both outputs are low, the words are equal. A mode input picks the number system at run time, either unsigned binary or two's complement. The P operand passes through a holding stage with an enable. While the enable is high, P flows straight through. While it is low, the last captured P is used. Reset clears the stored P to zero.

Each stage has two cascade inputs, one for greater and one for less, fed by the decisions of a less significant stage. Wider words are compared by chaining stages with no glue logic. The least significant stage gets both cascade inputs low. Only the most significant stage runs in two's complement mode. A stage whose local words differ decides by itself. A stage whose local words are equal passes on the cascade decision. The decision outputs are registered, so each stage adds one clock of latency to a chain.

Top module: `casc_mag_cmp`

## Requirements
- R1: A synchronous active-high reset clears the stored P operand to zero and drives both decision outputs low on the clock edge where reset is sampled high.
- R2: With `p_load` high, the compare uses the current `p_in` and the stored operand is updated at the clock edge. With `p_load` low, the compare uses the operand stored at the last edge where `p_load` was high, whatever `p_in` does.
- R3: With `unsigned_mode` = 1, the words are compared as unsigned binary numbers.
- R4: With `unsigned_mode` = 0, the words are compared as two's complement numbers, with bit WIDTH-1 as the sign bit.
- R5: The decision outputs are registered. Inputs present before a rising clock edge are reflected on `p_gt_q` and `p_lt_q` just after that edge.
- R6: When the effective P differs from Q, the local result sets the outputs and `casc_gt` and `casc_lt` have no effect.
- R7: When the effective P equals Q, `p_gt_q` copies `casc_gt` and `p_lt_q` copies `casc_lt`. With both cascade inputs low, both outputs are low, which signals equality.
- R8: When the words are equal and both cascade inputs are high (an illegal state), both outputs go low.
- R9: `p_gt_q` and `p_lt_q` are never high at the same time.
- R10: Three stages chained (the outputs of each stage feeding the cascade inputs of the next, the lowest stage with cascade inputs low, only the top stage in two's complement mode) compare 24-bit words correctly three clocks after the inputs settle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| p_load | input | 1 | P holding enable: 1 = pass and capture, 0 = hold |
| p_in | input | WIDTH | P operand |
| q_in | input | WIDTH | Q operand |
| unsigned_mode | input | 1 | 1 = unsigned compare, 0 = two's complement compare |
| casc_gt | input | 1 | Greater decision from a less significant stage |
| casc_lt | input | 1 | Less decision from a less significant stage |
| p_gt_q | output | 1 | Registered: P greater than Q |
| p_lt_q | output | 1 | Registered: P less than Q |

## Verification
The stage is driven with random operand pairs in both modes. Directed pairs that differ only in the sign bit show the two modes apart, since the unsigned and two's complement orders disagree there. Equal words are applied with all four cascade combinations, which separates pass-through from local decisions and covers the illegal both-high case. Stretches with `p_load` low and `p_in` changing show whether the held operand, and not the live input, is compared. A three-stage chain with 24-bit words, including words that differ only in low bytes, shows whether decisions travel correctly up the chain.

// File: rtl/cmp_pkg.sv
package cmp_pkg;
  typedef enum logic {
    CMP_SIGNED   = 1'b0,
    CMP_UNSIGNED = 1'b1
  } cmp_mode_e;

  typedef struct packed {
    logic gt;
    logic lt;
  } cmp_dec_t;
endpackage

// File: rtl/cmp_operand_hold.sv
module cmp_operand_hold #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q_eff
);
  logic [WIDTH-1:0] stored;

  always_ff @(posedge clk) begin
    if (rst)       stored <= '0;
    else if (load) stored <= d;
  end

  // transparent while load is high, held value otherwise
  assign q_eff = load ? d : stored;
endmodule

// File: rtl/cmp_sign_adjust.sv
module cmp_sign_adjust #(
  parameter int WIDTH = 8
) (
  input  cmp_pkg::cmp_mode_e mode,
  input  logic [WIDTH-1:0]   a,
  input  logic [WIDTH-1:0]   b,
  output logic [WIDTH-1:0]   a_adj,
  output logic [WIDTH-1:0]   b_adj
);
  localparam int MSB = WIDTH - 1;
  logic flip;

  assign flip = (mode == cmp_pkg::CMP_SIGNED);

  generate
    if (WIDTH > 1) begin : g_wide
      assign a_adj = {a[MSB] ^ flip, a[MSB-1:0]};
      assign b_adj = {b[MSB] ^ flip, b[MSB-1:0]};
    end else begin : g_narrow
      assign a_adj = a ^ flip;
      assign b_adj = b ^ flip;
    end
  endgenerate
endmodule

// File: rtl/cmp_magnitude.sv
module cmp_magnitude #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output cmp_pkg::cmp_dec_t dec
);
  logic [WIDTH-1:0] bit_gt;
  logic [WIDTH-1:0] bit_lt;

  genvar i;
  generate
    for (i = 0; i < WIDTH; i++) begin : g_bit
      assign bit_gt[i] = a[i] & ~b[i];
      assign bit_lt[i] = ~a[i] & b[i];
    end
  endgenerate

  // higher bit positions overwrite lower ones
  always_comb begin
    dec.gt = 1'b0;
    dec.lt = 1'b0;
    for (int k = 0; k < WIDTH; k++) begin
      if (bit_gt[k] | bit_lt[k]) begin
        dec.gt = bit_gt[k];
        dec.lt = bit_lt[k];
      end
    end
  end
endmodule

// File: rtl/cmp_cascade_merge.sv
module cmp_cascade_merge (
  input  logic              clk,
  input  logic              rst,
  input  cmp_pkg::cmp_dec_t local_dec,
  input  logic              cin_gt,
  input  logic              cin_lt,
  output logic              out_gt,
  output logic              out_lt
);
  logic nxt_gt;
  logic nxt_lt;
  logic decided;

  assign decided = local_dec.gt | local_dec.lt;

  always_comb begin
    if (decided) begin
      nxt_gt = local_dec.gt;
      nxt_lt = local_dec.lt;
    end else if (cin_gt & cin_lt) begin
      nxt_gt = 1'b0;
      nxt_lt = 1'b0;
    end else begin
      nxt_gt = cin_gt;
      nxt_lt = cin_lt;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_gt <= 1'b0;
      out_lt <= 1'b0;
    end else begin
      out_gt <= nxt_gt;
      out_lt <= nxt_lt;
    end
  end
endmodule

// File: rtl/casc_mag_cmp.sv
module casc_mag_cmp #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             p_load,
  input  logic [WIDTH-1:0] p_in,
  input  logic [WIDTH-1:0] q_in,
  input  logic             unsigned_mode,
  input  logic             casc_gt,
  input  logic             casc_lt,
  output logic             p_gt_q,
  output logic             p_lt_q
);
  logic [WIDTH-1:0]   p_eff;
  logic [WIDTH-1:0]   p_adj;
  logic [WIDTH-1:0]   q_adj;
  cmp_pkg::cmp_mode_e mode;
  cmp_pkg::cmp_dec_t  local_dec;

  assign mode = unsigned_mode ? cmp_pkg::CMP_UNSIGNED : cmp_pkg::CMP_SIGNED;

  cmp_operand_hold #(.WIDTH(WIDTH)) u_hold (
    .clk   (clk),
    .rst   (rst),
    .load  (p_load),
    .d     (p_in),
    .q_eff (p_eff)
  );

  cmp_sign_adjust #(.WIDTH(WIDTH)) u_sign (
    .mode  (mode),
    .a     (p_eff),
    .b     (q_in),
    .a_adj (p_adj),
    .b_adj (q_adj)
  );

  cmp_magnitude #(.WIDTH(WIDTH)) u_mag (
    .a   (p_adj),
    .b   (q_adj),
    .dec (local_dec)
  );

  cmp_cascade_merge u_merge (
    .clk       (clk),
    .rst       (rst),
    .local_dec (local_dec),
    .cin_gt    (casc_gt),
    .cin_lt    (casc_lt),
    .out_gt    (p_gt_q),
    .out_lt    (p_lt_q)
  );
endmodule

// File: rtl/casc_mag_cmp_chk.sv
module casc_mag_cmp_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             p_load,
  input logic [WIDTH-1:0] p_in,
  input logic [WIDTH-1:0] q_in,
  input logic             unsigned_mode,
  input logic             casc_gt,
  input logic             casc_lt,
  input logic             p_gt_q,
  input logic             p_lt_q
);
  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (!p_gt_q && !p_lt_q)); // R1

  AST_NEVER_BOTH: assert property (@(posedge clk) disable iff (rst) !(p_gt_q && p_lt_q)); // R9

  AST_UNSIGNED_GT: assert property (@(posedge clk) disable iff (rst)
    (p_load && unsigned_mode && (p_in > q_in)) |=> (p_gt_q && !p_lt_q)); // R3

  AST_SIGNED_LT: assert property (@(posedge clk) disable iff (rst)
    (p_load && !unsigned_mode && ($signed(p_in) < $signed(q_in))) |=> (p_lt_q && !p_gt_q)); // R4

  AST_EQ_PASS_GT: assert property (@(posedge clk) disable iff (rst)
    (p_load && (p_in == q_in) && casc_gt && !casc_lt) |=> (p_gt_q && !p_lt_q)); // R7

  AST_EQ_ILLEGAL_LOW: assert property (@(posedge clk) disable iff (rst)
    (p_load && (p_in == q_in) && casc_gt && casc_lt) |=> (!p_gt_q && !p_lt_q)); // R8
endmodule

bind casc_mag_cmp casc_mag_cmp_chk #(.WIDTH(WIDTH)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .p_load        (p_load),
  .p_in          (p_in),
  .q_in          (q_in),
  .unsigned_mode (unsigned_mode),
  .casc_gt       (casc_gt),
  .casc_lt       (casc_lt),
  .p_gt_q        (p_gt_q),
  .p_lt_q        (p_lt_q)
);

// File: tb/casc_mag_cmp_bench.sv
module casc_mag_cmp_bench;
  localparam int W = 8;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic         rst = 1'b1;
  logic         p_load = 1'b0;
  logic [W-1:0] p_in = '0;
  logic [W-1:0] q_in = '0;
  logic         unsigned_mode = 1'b1;
  logic         casc_gt = 1'b0;
  logic         casc_lt = 1'b0;
  logic         p_gt_q, p_lt_q;

  casc_mag_cmp #(.WIDTH(W)) u_casc_mag_cmp (
    .clk(clk), .rst(rst), .p_load(p_load), .p_in(p_in), .q_in(q_in),
    .unsigned_mode(unsigned_mode), .casc_gt(casc_gt), .casc_lt(casc_lt),
    .p_gt_q(p_gt_q), .p_lt_q(p_lt_q)
  );

  // three-stage chain for 24-bit words
  logic [23:0] ca = '0;
  logic [23:0] cb = '0;
  logic        chain_mode = 1'b1;
  logic [2:0]  cg, cl;

  genvar s;
  generate
    for (s = 0; s < 3; s++) begin : g_chain
      casc_mag_cmp #(.WIDTH(8)) u_stage (
        .clk(clk), .rst(rst), .p_load(1'b1),
        .p_in(ca[8*s +: 8]), .q_in(cb[8*s +: 8]),
        .unsigned_mode((s == 2) ? chain_mode : 1'b1),
        .casc_gt((s == 0) ? 1'b0 : cg[(s == 0) ? 0 : s-1]),
        .casc_lt((s == 0) ? 1'b0 : cl[(s == 0) ? 0 : s-1]),
        .p_gt_q(cg[s]), .p_lt_q(cl[s])
      );
    end
  endgenerate

  int checks = 0;
  int fails = 0;
  logic [W-1:0] model_hold = '0;

  task automatic check2(input string req, input logic ag, input logic al,
                        input logic eg, input logic el);
    checks++;
    if (ag !== eg || al !== el) begin
      fails++;
      $display("FAIL %s: got gt=%b lt=%b expected gt=%b lt=%b", req, ag, al, eg, el);
    end
  endtask

  function automatic void ref_dec(input logic [W-1:0] p, input logic [W-1:0] q,
                                  input logic um, input logic cg_i, input logic cl_i,
                                  output logic eg, output logic el);
    int pv, qv;
    if (um) begin
      pv = int'(p);
      qv = int'(q);
    end else begin
      pv = int'($signed(p));
      qv = int'($signed(q));
    end
    if (pv > qv)      begin eg = 1'b1; el = 1'b0; end
    else if (pv < qv) begin eg = 1'b0; el = 1'b1; end
    else if (cg_i && cl_i) begin eg = 1'b0; el = 1'b0; end
    else              begin eg = cg_i; el = cl_i; end
  endfunction

  // one clock: inputs set at negedge, expectation formed, checked at next negedge
  task automatic step(input string req, input logic ld, input logic [W-1:0] p,
                      input logic [W-1:0] q, input logic um,
                      input logic cgi, input logic cli);
    logic eg, el;
    logic [W-1:0] peff;
    p_load = ld; p_in = p; q_in = q; unsigned_mode = um;
    casc_gt = cgi; casc_lt = cli;
    peff = ld ? p : model_hold;
    if (rst) begin eg = 1'b0; el = 1'b0; end
    else ref_dec(peff, q, um, cgi, cli, eg, el);
    @(posedge clk);
    if (rst) model_hold = '0;
    else if (ld) model_hold = p;
    @(negedge clk);
    check2(req, p_gt_q, p_lt_q, eg, el);
  endtask

  task automatic chain_check(input string req, input logic [23:0] a,
                             input logic [23:0] b, input logic um);
    logic eg, el;
    int av, bv;
    ca = a; cb = b; chain_mode = um;
    if (um) begin av = int'(a); bv = int'(b); end
    else begin av = int'($signed(a)); bv = int'($signed(b)); end
    eg = av > bv;
    el = av < bv;
    repeat (4) @(negedge clk);
    check2(req, cg[2], cl[2], eg, el);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    // R1: reset state
    step("R1", 1'b1, 8'hAA, 8'h11, 1'b1, 1'b1, 1'b0);
    step("R1", 1'b0, 8'h55, 8'h00, 1'b1, 1'b0, 1'b0);
    rst = 1'b0;
    // R1: held operand is zero right after reset
    step("R1", 1'b0, 8'hFF, 8'h01, 1'b1, 1'b0, 1'b0);
    step("R1", 1'b0, 8'hFF, 8'h00, 1'b1, 1'b0, 1'b0);

    // R3 / R4: sign-bit pairs show the modes apart
    step("R3", 1'b1, 8'h80, 8'h7F, 1'b1, 1'b0, 1'b0);
    step("R4", 1'b1, 8'h80, 8'h7F, 1'b0, 1'b0, 1'b0);
    step("R3", 1'b1, 8'h01, 8'hFF, 1'b1, 1'b0, 1'b0);
    step("R4", 1'b1, 8'h01, 8'hFF, 1'b0, 1'b0, 1'b0);
    step("R4", 1'b1, 8'hFE, 8'hFF, 1'b0, 1'b0, 1'b0);

    // R6: unequal words ignore cascade inputs
    step("R6", 1'b1, 8'h10, 8'h20, 1'b1, 1'b1, 1'b0);
    step("R6", 1'b1, 8'h30, 8'h20, 1'b1, 1'b0, 1'b1);
    step("R6", 1'b1, 8'h30, 8'h20, 1'b0, 1'b1, 1'b1);

    // R7 / R8: equal words with all cascade combinations
    step("R7", 1'b1, 8'h42, 8'h42, 1'b1, 1'b0, 1'b0);
    step("R7", 1'b1, 8'h42, 8'h42, 1'b1, 1'b1, 1'b0);
    step("R7", 1'b1, 8'h9C, 8'h9C, 1'b0, 1'b0, 1'b1);
    step("R8", 1'b1, 8'h9C, 8'h9C, 1'b0, 1'b1, 1'b1);

    // R2: capture 0x40, then hold while p_in and q_in move
    step("R2", 1'b1, 8'h40, 8'h40, 1'b1, 1'b0, 1'b0);
    step("R2", 1'b0, 8'hFF, 8'h41, 1'b1, 1'b0, 1'b0);
    step("R2", 1'b0, 8'h00, 8'h3F, 1'b1, 1'b0, 1'b0);
    step("R2", 1'b0, 8'h12, 8'h40, 1'b1, 1'b1, 1'b0);
    step("R2", 1'b1, 8'h05, 8'h04, 1'b1, 1'b0, 1'b0);
    step("R2", 1'b0, 8'hF0, 8'h05, 1'b1, 1'b0, 1'b1);

    // R5 / R9: random traffic, checked one clock after each input set
    for (int n = 0; n < 400; n++) begin
      logic [W-1:0] rp, rq;
      logic rc1, rc2;
      rp = W'($urandom);
      rq = (n % 5 == 0) ? rp : W'($urandom);
      rc1 = 1'($urandom);
      rc2 = 1'($urandom);
      step((n % 2 == 0) ? "R5" : "R9", 1'($urandom_range(0, 3) != 0), rp, rq,
           1'($urandom), rc1, rc2);
    end

    // R10: three-stage 24-bit chain in both modes
    chain_check("R10", 24'h000001, 24'h000002, 1'b1);
    chain_check("R10", 24'h123457, 24'h123456, 1'b1);
    chain_check("R10", 24'h800000, 24'h7FFFFF, 1'b1);
    chain_check("R10", 24'h800000, 24'h7FFFFF, 1'b0);
    chain_check("R10", 24'hFFFF00, 24'hFFFF01, 1'b0);
    chain_check("R10", 24'hABCDEF, 24'hABCDEF, 1'b0);
    chain_check("R10", 24'h00FF00, 24'h0100FF, 1'b1);
    for (int n = 0; n < 40; n++) begin
      logic [23:0] ra, rb;
      ra = 24'($urandom);
      rb = (n % 4 == 0) ? {ra[23:8], 8'($urandom)} : 24'($urandom);
      chain_check("R10", ra, rb, 1'($urandom));
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule